// File: doc/BRIEF.md
# Correlation Peak Acquisition Search

This block sits after a bank of correlators in a pulsed radio receiver. Each correlator result belongs to one candidate timing offset. The results are written one at a time into a store of 50 signed entries. A start pulse then launches a search over the whole store. The search finds the offset whose result has the largest magnitude. It also reads the results at the offsets on either side of that peak. The peak magnitude is compared with a threshold to decide whether a signal is present.

The search also decides how to hand over to the tracking loop. It looks at the peak paired with its lower neighbour and the peak paired with its upper neighbour, and picks the pair with the greater combined energy. The lower and upper neighbour offsets wrap around the ends of the offset range.

The detection verdict arrives first. The position, the values and the pairing choice follow a fixed number of slow-clock cycles later. A synchronous clear empties the store and drops the verdict. The threshold is a static configuration input, which is loaded before operation and held steady during a search.

Top module: `peak_acq_search`

## Requirements
- R1: With `wr_en` high and no search running, `wr_val` is stored at offset `wr_idx` (0 to 49). A write to an index of 50 or above is ignored. A write made while `busy` is high is ignored.
- R2: `peak_pos` is the offset whose stored value has the largest magnitude. When several offsets share that magnitude, the lowest offset is reported. `peak_val` is the signed value stored at that offset.
- R3: On the clock edge 6 cycles after the edge that accepts a start, `det_valid` pulses high for one cycle. On that same edge, `detected` becomes 1 when the peak magnitude is greater than or equal to `thresh` (read as unsigned), and 0 otherwise. `detected` then holds until the next verdict.
- R4: A start is accepted only while `busy` is low. `busy` is high from the accepting edge until the edge 13 cycles later. On that later edge, `res_valid` pulses high for one cycle and `peak_pos`, `peak_val`, `lo_val`, `hi_val` and `pair_upper` take new values, which they then hold. A start pulse seen while `busy` is high has no effect.
- R5: `lo_val` is the stored value at offset `peak_pos-1`, with offset 49 used when the peak is at 0. `hi_val` is the stored value at offset `peak_pos+1`, with offset 0 used when the peak is at 49.
- R6: `pair_upper` is 1 when `peak_val² + hi_val²` is strictly greater than `peak_val² + lo_val²`. Otherwise it is 0, so a tie selects the lower pair.
- R7: Values are 11-bit two's complement. The most negative value, -1024, has magnitude 1024, which is larger than the magnitude of +1023.
- R8: `clr` sets every stored value to zero, ends any running search, and zeroes `detected`, the result outputs and both valid pulses. Writes and starts made in the same cycle as `clr` are ignored.
- R9: After reset, all outputs are zero and the store holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of store, search and results |
| wr_en | input | 1 | Write strobe for one correlation result |
| wr_idx | input | 6 | Offset that the written result belongs to |
| wr_val | input | 11 | Signed correlation result |
| start | input | 1 | Launches a search over the store |
| thresh | input | 11 | Unsigned detection threshold on the peak magnitude |
| busy | output | 1 | A search is running |
| det_valid | output | 1 | One-cycle pulse when the verdict updates |
| detected | output | 1 | Peak magnitude reached the threshold |
| res_valid | output | 1 | One-cycle pulse when the results update |
| peak_pos | output | 6 | Offset of the peak |
| peak_val | output | 11 | Signed value at the peak |
| lo_val | output | 11 | Signed value at the lower neighbour |
| hi_val | output | 11 | Signed value at the upper neighbour |
| pair_upper | output | 1 | 1 selects the peak with upper neighbour, 0 the lower |

## Verification
Counting from the edge that accepts a start, the verdict is due on the sixth edge and the position, values and pairing are due on the thirteenth. Each of these outputs must hold steady from one update to the next.

The bench model counts its own age per search. It updates its expected outputs on exactly those edges and freezes them at all other times. Every output is compared on the falling edge of every cycle, so an update that comes one cycle early or late, or that drifts between updates, is reported.

Directed cases cover these situations:
- the ends of the offset range, where the neighbours wrap;
- ties between equal peak magnitudes and between equal neighbour magnitudes;
- the most negative value;
- the threshold boundary;
- writes and starts that must be ignored.

// File: rtl/pks_pkg.sv
// Package: default sizes and the sequencer phase type shared by the
// correlation peak search modules.
package pks_pkg;
    localparam int PKS_NUM_POS  = 50;   // candidate timing offsets
    localparam int PKS_VAL_W    = 11;   // signed correlation width
    localparam int PKS_LANES    = 10;   // entries examined per scan cycle
    localparam int PKS_REST_LAT = 7;    // cycles from verdict to results

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_POST = 2'd2
    } seq_phase_e;
endpackage

// File: rtl/pks_store.sv
// Module: pks_store
// Holds one signed correlation result per candidate offset.
// Assumes: the caller blocks writes during a search; an index of
// NUM_POS or more matches no entry and is dropped here.
module pks_store #(
    parameter  int NUM_POS = 50,
    parameter  int VAL_W   = 11,
    localparam int IDX_W   = $clog2(NUM_POS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic signed [VAL_W-1:0] wval,
    output logic signed [VAL_W-1:0] vals [NUM_POS]
);

    // Entry update: zero on reset or clear, otherwise take the addressed write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_POS; i++) begin
            if (!rst_n || clr) begin
                vals[i] <= '0;
            end else if (we && (widx == IDX_W'(i))) begin
                vals[i] <= wval;
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && (int'(widx) < NUM_POS)) |=> (vals[$past(widx)] == $past(wval)))
        else $error("write did not land"); // R1

endmodule

// File: rtl/pks_scan.sv
// Module: pks_scan
// Running largest-magnitude search, LANES entries per step, chunks
// taken in rising index order.
// Assumes: init comes one cycle before the first step, and the store
// does not change while stepping. A strict compare keeps the lowest
// index on equal magnitudes.
module pks_scan #(
    parameter  int NUM_POS = 50,
    parameter  int VAL_W   = 11,
    parameter  int LANES   = 10,
    localparam int IDX_W   = $clog2(NUM_POS),
    localparam int NCHUNK  = (NUM_POS + LANES - 1) / LANES,
    localparam int CH_W    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    init,
    input  logic                    step,
    input  logic [CH_W-1:0]         chunk,
    input  logic signed [VAL_W-1:0] vals [NUM_POS],
    output logic [IDX_W-1:0]        best_pos,
    output logic [VAL_W-1:0]        best_mag
);

    // Two's complement magnitude; the most negative code maps to 2^(VAL_W-1).
    function automatic logic [VAL_W-1:0] mag_of(input logic signed [VAL_W-1:0] v);
        logic [VAL_W-1:0] r;
        r = v;
        if (v[VAL_W-1]) begin
            r = ~r + {{(VAL_W-1){1'b0}}, 1'b1};
        end
        return r;
    endfunction

    logic [IDX_W-1:0] cand_pos;
    logic [VAL_W-1:0] cand_mag;

    // Candidate: running best against this chunk's lanes, lowest index first.
    always_comb begin
        int               idx;
        logic [IDX_W-1:0] ix;
        logic [VAL_W-1:0] m;
        cand_pos = best_pos;
        cand_mag = best_mag;
        for (int j = 0; j < LANES; j++) begin
            idx = int'(chunk) * LANES + j;
            ix  = IDX_W'(idx);
            m   = mag_of(vals[ix]);
            if ((idx < NUM_POS) && (m > cand_mag)) begin
                cand_mag = m;
                cand_pos = ix;
            end
        end
    end

    // Best register: cleared on init, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || init) begin
            best_pos <= '0;
            best_mag <= '0;
        end else if (step) begin
            best_pos <= cand_pos;
            best_mag <= cand_mag;
        end
    end

    AST_PEAK_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !init) |=> (best_mag >= $past(best_mag)))
        else $error("peak magnitude fell during scan"); // R2

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(best_pos) < NUM_POS)
        else $error("peak position out of range"); // R2

endmodule

// File: rtl/pks_pair.sv
// Module: pks_pair
// Captures the peak and its two neighbours (offsets wrap at the ends),
// then picks the neighbour whose pair with the peak has the greater
// energy.
// Assumes: decide comes one cycle after fetch, with the store unchanged.
module pks_pair #(
    parameter  int NUM_POS = 50,
    parameter  int VAL_W   = 11,
    localparam int IDX_W   = $clog2(NUM_POS),
    localparam int SQ_W    = 2 * VAL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    fetch,
    input  logic                    decide,
    input  logic [IDX_W-1:0]        peak_pos,
    input  logic signed [VAL_W-1:0] vals [NUM_POS],
    output logic signed [VAL_W-1:0] p_val,
    output logic signed [VAL_W-1:0] lo_val,
    output logic signed [VAL_W-1:0] hi_val,
    output logic                    upper
);

    // Two's complement magnitude, as in the scan.
    function automatic logic [VAL_W-1:0] mag_of(input logic signed [VAL_W-1:0] v);
        logic [VAL_W-1:0] r;
        r = v;
        if (v[VAL_W-1]) begin
            r = ~r + {{(VAL_W-1){1'b0}}, 1'b1};
        end
        return r;
    endfunction

    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    logic [SQ_W:0]    e_lo;
    logic [SQ_W:0]    e_hi;
    logic [SQ_W-1:0]  sq_p;
    logic [SQ_W-1:0]  sq_lo;
    logic [SQ_W-1:0]  sq_hi;

    // Neighbour offsets, wrapping modulo NUM_POS.
    always_comb begin
        lo_idx = (peak_pos == '0) ? IDX_W'(NUM_POS - 1) : peak_pos - IDX_W'(1);
        hi_idx = (peak_pos == IDX_W'(NUM_POS - 1)) ? '0 : peak_pos + IDX_W'(1);
    end

    // Pair energies as sums of squared magnitudes.
    always_comb begin
        sq_p  = SQ_W'(mag_of(p_val))  * SQ_W'(mag_of(p_val));
        sq_lo = SQ_W'(mag_of(lo_val)) * SQ_W'(mag_of(lo_val));
        sq_hi = SQ_W'(mag_of(hi_val)) * SQ_W'(mag_of(hi_val));
        e_lo  = {1'b0, sq_p} + {1'b0, sq_lo};
        e_hi  = {1'b0, sq_p} + {1'b0, sq_hi};
    end

    // Capture the three values on fetch; record the pairing on decide.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            p_val  <= '0;
            lo_val <= '0;
            hi_val <= '0;
            upper  <= 1'b0;
        end else begin
            if (fetch) begin
                p_val  <= vals[peak_pos];
                lo_val <= vals[lo_idx];
                hi_val <= vals[hi_idx];
            end
            if (decide) begin
                upper <= (e_hi > e_lo);
            end
        end
    end

    AST_PAIR_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !clr && !fetch) |=> (upper == (mag_of(hi_val) > mag_of(lo_val))))
        else $error("pairing does not follow neighbour energy"); // R6

    AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !clr && (peak_pos == '0)) |=> (lo_val == $past(vals[NUM_POS-1])))
        else $error("lower neighbour did not wrap"); // R5

    AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !clr && (peak_pos == IDX_W'(NUM_POS - 1))) |=> (hi_val == $past(vals[0])))
        else $error("upper neighbour did not wrap"); // R5

endmodule

// File: rtl/peak_acq_search.sv
// Module: peak_acq_search (top)
// Stores one correlation result per offset. On start it scans the store
// in chunks, gives a threshold verdict, then reports the peak, its
// neighbours and the stronger pairing.
// Assumes: thresh is held steady during a search; REST_LAT >= 3.
module peak_acq_search
    import pks_pkg::*;
#(
    parameter  int NUM_POS   = PKS_NUM_POS,
    parameter  int VAL_W     = PKS_VAL_W,
    parameter  int LANES     = PKS_LANES,
    parameter  int REST_LAT  = PKS_REST_LAT,
    localparam int IDX_W     = $clog2(NUM_POS),
    localparam int NCHUNK    = (NUM_POS + LANES - 1) / LANES,
    localparam int CH_W      = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
    localparam int DET_AT    = NCHUNK + 1,
    localparam int FETCH_AT  = DET_AT + 1,
    localparam int DECIDE_AT = DET_AT + 2,
    localparam int DONE_AT   = DET_AT + REST_LAT,
    localparam int CNT_W     = $clog2(DONE_AT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic signed [VAL_W-1:0] wr_val,
    input  logic                    start,
    input  logic [VAL_W-1:0]        thresh,
    output logic                    busy,
    output logic                    det_valid,
    output logic                    detected,
    output logic                    res_valid,
    output logic [IDX_W-1:0]        peak_pos,
    output logic signed [VAL_W-1:0] peak_val,
    output logic signed [VAL_W-1:0] lo_val,
    output logic signed [VAL_W-1:0] hi_val,
    output logic                    pair_upper
);

    logic [CNT_W-1:0]        cnt;
    seq_phase_e              phase;
    logic                    accept;
    logic                    step;
    logic [CH_W-1:0]         chunk;
    logic                    at_det;
    logic                    at_fetch;
    logic                    at_decide;
    logic                    at_done;
    logic signed [VAL_W-1:0] vals [NUM_POS];
    logic [IDX_W-1:0]        best_pos;
    logic [VAL_W-1:0]        best_mag;
    logic signed [VAL_W-1:0] pr_p;
    logic signed [VAL_W-1:0] pr_lo;
    logic signed [VAL_W-1:0] pr_hi;
    logic                    pr_upper;

    // Phase decode from the search age counter.
    always_comb begin
        accept    = !busy && start;
        at_det    = busy && (cnt == CNT_W'(DET_AT));
        at_fetch  = busy && (cnt == CNT_W'(FETCH_AT));
        at_decide = busy && (cnt == CNT_W'(DECIDE_AT));
        at_done   = busy && (cnt == CNT_W'(DONE_AT));
        if (!busy) begin
            phase = SEQ_IDLE;
        end else if ((cnt >= CNT_W'(1)) && (cnt <= CNT_W'(NCHUNK))) begin
            phase = SEQ_SCAN;
        end else begin
            phase = SEQ_POST;
        end
        step  = (phase == SEQ_SCAN);
        chunk = CH_W'(cnt - CNT_W'(1));
    end

    // Search age counter: starts at 1 on accept and runs until DONE_AT.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(1);
            end
        end else if (at_done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    pks_store #(.NUM_POS(NUM_POS), .VAL_W(VAL_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .we    (wr_en && !busy),
        .widx  (wr_idx),
        .wval  (wr_val),
        .vals  (vals)
    );

    pks_scan #(.NUM_POS(NUM_POS), .VAL_W(VAL_W), .LANES(LANES)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .init     (accept),
        .step     (step),
        .chunk    (chunk),
        .vals     (vals),
        .best_pos (best_pos),
        .best_mag (best_mag)
    );

    pks_pair #(.NUM_POS(NUM_POS), .VAL_W(VAL_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .fetch    (at_fetch),
        .decide   (at_decide),
        .peak_pos (best_pos),
        .vals     (vals),
        .p_val    (pr_p),
        .lo_val   (pr_lo),
        .hi_val   (pr_hi),
        .upper    (pr_upper)
    );

    // Verdict: threshold test on the finished scan, one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            det_valid <= 1'b0;
            detected  <= 1'b0;
        end else begin
            det_valid <= at_det;
            if (at_det) begin
                detected <= (best_mag >= thresh);
            end
        end
    end

    // Results: publish position, values and pairing together.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            res_valid  <= 1'b0;
            peak_pos   <= '0;
            peak_val   <= '0;
            lo_val     <= '0;
            hi_val     <= '0;
            pair_upper <= 1'b0;
        end else begin
            res_valid <= at_done;
            if (at_done) begin
                peak_pos   <= best_pos;
                peak_val   <= pr_p;
                lo_val     <= pr_lo;
                hi_val     <= pr_hi;
                pair_upper <= pr_upper;
            end
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !clr) |=> busy)
        else $error("accepted start did not raise busy"); // R4

    AST_RES_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!busy && $past(busy)))
        else $error("result pulse outside search end"); // R4

    AST_DET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |=> !det_valid)
        else $error("verdict pulse longer than one cycle"); // R3

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !$past(clr)) |-> $stable(peak_pos))
        else $error("peak position moved between results"); // R4

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!detected && !res_valid && !busy && (peak_pos == '0)))
        else $error("clear left state behind"); // R8

endmodule

// File: tb/sim_peak_acq_search.sv
module sim_peak_acq_search;

    localparam int NP = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_idx = '0;
    logic signed [10:0] wr_val = '0;
    logic              start = 1'b0;
    logic [10:0]       thresh = '0;
    logic              busy, det_valid, detected, res_valid, pair_upper;
    logic [5:0]        peak_pos;
    logic signed [10:0] peak_val, lo_val, hi_val;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int  mem_m [NP];
    int  age = -1;
    bit  cmp_on = 1'b0;
    int  e_busy, e_dv, e_det, e_rv, e_pos, e_pv, e_lo, e_hi, e_up;
    int  pat [NP];

    always #10 clk = ~clk;

    peak_acq_search u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_val(wr_val), .start(start), .thresh(thresh), .busy(busy),
        .det_valid(det_valid), .detected(detected), .res_valid(res_valid),
        .peak_pos(peak_pos), .peak_val(peak_val), .lo_val(lo_val),
        .hi_val(hi_val), .pair_upper(pair_upper)
    );

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int argmax_m();
        int bp = 0;
        for (int i = 1; i < NP; i++) begin
            if (absv(mem_m[i]) > absv(mem_m[bp])) bp = i;
        end
        return bp;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            age = -1;
            for (int i = 0; i < NP; i++) mem_m[i] = 0;
            e_busy = 0; e_dv = 0; e_det = 0; e_rv = 0;
            e_pos = 0; e_pv = 0; e_lo = 0; e_hi = 0; e_up = 0;
            cmp_on = 1'b1;
        end else begin
            bit busy_old;
            busy_old = (age >= 0);
            e_dv = 0;
            e_rv = 0;
            if (wr_en && !busy_old && (int'(wr_idx) < NP)) mem_m[wr_idx] = int'(wr_val);
            if (busy_old) begin
                age++;
                if (age == 6) begin
                    e_dv  = 1;
                    e_det = (absv(mem_m[argmax_m()]) >= int'(thresh)) ? 1 : 0;
                end
                if (age == 13) begin
                    int p, l, h;
                    e_rv  = 1;
                    e_pos = argmax_m();
                    p = mem_m[e_pos];
                    l = mem_m[(e_pos + NP - 1) % NP];
                    h = mem_m[(e_pos + 1) % NP];
                    e_pv = p; e_lo = l; e_hi = h;
                    e_up = ((p * p + h * h) > (p * p + l * l)) ? 1 : 0;
                    age = -1;
                end
            end else if (start) begin
                age = 0;
            end
            e_busy = (age >= 0) ? 1 : 0;
        end
    end

    // Every-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R4", "busy", int'(busy), e_busy);
            chk("R3", "det_valid", int'(det_valid), e_dv);
            chk("R3", "detected", int'(detected), e_det);
            chk("R4", "res_valid", int'(res_valid), e_rv);
            chk("R2", "peak_pos", int'(peak_pos), e_pos);
            chk("R2", "peak_val", int'(peak_val), e_pv);
            chk("R5", "lo_val", int'(lo_val), e_lo);
            chk("R5", "hi_val", int'(hi_val), e_hi);
            chk("R6", "pair_upper", int'(pair_upper), e_up);
        end
    end

    task automatic wr(int idx, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_val = 11'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_pat();
        for (int i = 0; i < NP; i++) wr(i, pat[i]);
    endtask

    task automatic clear_pat();
        for (int i = 0; i < NP; i++) pat[i] = 0;
    endtask

    task automatic run_search();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic check_result(string req, int pos, int pv, int lo, int hi, int up);
        chk(req, "result peak_pos", int'(peak_pos), pos);
        chk(req, "result peak_val", int'(peak_val), pv);
        chk(req, "result lo_val", int'(lo_val), lo);
        chk(req, "result hi_val", int'(hi_val), hi);
        chk(req, "result pair_upper", int'(pair_upper), up);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int res_pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check_result("R9", 0, 0, 0, 0, 0);
        chk("R9", "reset detected", int'(detected), 0);
        chk("R9", "reset busy", int'(busy), 0);

        // R2 R6: interior peak, upper neighbour stronger
        thresh = 11'd100;
        clear_pat(); pat[16] = -50; pat[17] = 300; pat[18] = 80;
        load_pat(); run_search();
        check_result("R2", 17, 300, -50, 80, 1);
        chk("R3", "detected above threshold", int'(detected), 1);

        // R5: peak at offset 0, lower neighbour wraps to 49
        clear_pat(); pat[0] = -500; pat[49] = 200; pat[1] = 100;
        load_pat(); run_search();
        check_result("R5", 0, -500, 200, 100, 0);

        // R5: peak at offset 49, upper neighbour wraps to 0
        clear_pat(); pat[49] = 400; pat[48] = 10; pat[0] = -30;
        load_pat(); run_search();
        check_result("R5", 49, 400, 10, -30, 1);

        // R2: equal magnitudes, lowest offset wins
        clear_pat(); pat[5] = 250; pat[30] = -250;
        load_pat(); run_search();
        chk("R2", "tie lowest index", int'(peak_pos), 5);

        // R7: most negative code beats +1023
        clear_pat(); pat[20] = 1023; pat[40] = -1024;
        load_pat(); run_search();
        chk("R7", "full negative peak_pos", int'(peak_pos), 40);
        chk("R7", "full negative peak_val", int'(peak_val), -1024);

        // R3: threshold boundary
        clear_pat(); pat[10] = 300;
        load_pat();
        thresh = 11'd300; run_search();
        chk("R3", "equal to threshold", int'(detected), 1);
        thresh = 11'd301; run_search();
        chk("R3", "one below threshold", int'(detected), 0);

        // R6: equal neighbour magnitudes choose the lower pair
        clear_pat(); pat[25] = 200; pat[24] = -60; pat[26] = 60;
        load_pat(); run_search();
        chk("R6", "neighbour tie", int'(pair_upper), 0);

        // R1: out-of-range index and writes during a search are ignored
        clear_pat(); pat[7] = 100;
        load_pat();
        wr(55, 900);
        run_search();
        chk("R1", "out-of-range write ignored", int'(peak_pos), 7);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; wr_en = 1'b1; wr_idx = 6'd3; wr_val = 11'sd1000;
        @(negedge clk); wr_en = 1'b0;
        repeat (13) @(negedge clk);
        run_search();
        chk("R1", "write during busy ignored", int'(peak_pos), 7);
        chk("R1", "write during busy ignored val", int'(peak_val), 100);

        // R4: a start during a search is ignored
        clear_pat(); pat[33] = 77; load_pat();
        res_pulses = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (res_valid) res_pulses++;
        end
        chk("R4", "one result per accepted start", res_pulses, 1);

        // R8: clear empties store and verdict
        thresh = 11'd1;
        @(negedge clk); clr = 1'b1; start = 1'b1; wr_en = 1'b1; wr_idx = 6'd2; wr_val = 11'sd500;
        @(negedge clk); clr = 1'b0; start = 1'b0; wr_en = 1'b0;
        chk("R8", "detected after clear", int'(detected), 0);
        chk("R8", "busy after clear", int'(busy), 0);
        check_result("R8", 0, 0, 0, 0, 0);
        run_search();
        chk("R8", "empty store verdict", int'(detected), 0);
        chk("R8", "empty store peak_pos", int'(peak_pos), 0);

        // mixed patterns against the model
        thresh = 11'd600;
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < NP; i++) pat[i] = int'($urandom_range(0, 2047)) - 1024;
            load_pat(); run_search();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule